// File: doc/BRIEF.md
# Masked Content Addressable Memory

This block is a small content addressable memory. It holds a set of words, and each word has a valid flag. A search compares an argument with every stored word in the same cycle. A key vector selects which bit positions take part in that compare. The result for each word is kept in a match register, one bit per word.

After a search, read strobes take the matched words out of the memory in turn, from the lowest index to the highest. A done flag shows when no matches are left to read. A write port stores a word at a chosen index and marks that word valid. The write port takes priority over the search and read operations, and a write also drops any readout that is still pending.

The top module applies the write, search and read requests in that order of priority, so only one operation takes effect in any cycle.

Top module: `masked_cam`

## Requirements
- R1: After reset, match_o is all zeros, rd_done_o is 1 and rd_valid_o is 0. Every word is invalid, so a search made before any write leaves match_o at zero.
- R2: A write (wr_en_i = 1) stores wr_data_i at index wr_idx_i and sets that word valid. A later search whose argument equals the stored data under a full key finds the word at that index.
- R3: A search (srch_en_i = 1, wr_en_i = 0) sets match_o bit i in the following cycle exactly when word i is valid and ((word_i XOR arg_i) AND key_i) is zero. Bit positions where key_i is 0 are ignored.
- R4: A search with key_i all zeros sets the match bit of every valid word.
- R5: A word that has never been written never matches, whatever the argument and key.
- R6: A read strobe (rd_en_i = 1, with wr_en_i = 0 and srch_en_i = 0) made while match_o is nonzero has these effects in the next cycle: rd_valid_o is 1, rd_idx_o is the lowest set match index, rd_data_o is the word stored at that index, and that match bit is cleared.
- R7: A read strobe made while match_o is zero gives rd_valid_o = 0 in the next cycle and leaves match_o at zero.
- R8: rd_done_o is 1 exactly when match_o is all zeros.
- R9: When wr_en_i is 1, any search or read request in the same cycle is ignored. The write still takes effect, match_o is zero in the next cycle and rd_valid_o is 0.
- R10: A search replaces the whole match register. Bits that are left over from an earlier search and do not match the new argument are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request (highest priority) |
| wr_idx_i | input | 4 | Index of the word to write |
| wr_data_i | input | 8 | Data to write |
| srch_en_i | input | 1 | Search request |
| arg_i | input | 8 | Search argument |
| key_i | input | 8 | Compare mask; a 1 enables that bit |
| rd_en_i | input | 1 | Read strobe for the next matched word |
| match_o | output | 16 | Match register, one bit per word |
| rd_done_o | output | 1 | High when no match bits remain |
| rd_valid_o | output | 1 | A matched word is presented this cycle |
| rd_idx_o | output | 4 | Index of the word that was read |
| rd_data_o | output | 8 | Data of the word that was read |

## Verification
The bench builds the block with its default parameters: 16 words of 8 bits. With these values a random index can reach every word, including words 0 and 15, and a draw of random keys often gives the all-zero key and the all-ones key. With only 8 data bits, masked searches frequently find several words at once. This means readout walks through multi-word match sets and runs past the last match into empty reads. Requests for write together with search, and for write together with read, are issued deliberately to exercise the priority order.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    OP_IDLE,
    OP_WRITE,
    OP_SEARCH,
    OP_READ
  } cam_op_e;
endpackage

// File: rtl/cam_word.sv
module cam_word #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] arg_i,
  input  logic [WORD_W-1:0] key_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              hit_o
);
  logic [WORD_W-1:0] data_q;
  logic              valid_q;
  logic [WORD_W-1:0] bit_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (we_i) begin
      data_q  <= wdata_i;
      valid_q <= 1'b1;
    end
  end

  // per-bit compare cell; masked-off positions always agree
  for (genvar b = 0; b < WORD_W; b++) begin : g_cell
    assign bit_ok[b] = ~key_i[b] | ~(data_q[b] ^ arg_i[b]);
  end

  assign hit_o   = valid_q & (&bit_ok);
  assign data_o  = data_q;
  assign valid_o = valid_q;

  AST_WR_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_o && data_o == $past(wdata_i))); // R2
endmodule

// File: rtl/cam_first_sel.sv
module cam_first_sel #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     oh_o
);
  always_comb begin
    idx_o = '0;
    oh_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        oh_o  = N'(1) << i;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 8,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic                 srch_en_i,
  input  logic [WORD_W-1:0]    arg_i,
  input  logic [WORD_W-1:0]    key_i,
  input  logic                 rd_en_i,
  output logic [NUM_WORDS-1:0] match_o,
  output logic                 rd_done_o,
  output logic                 rd_valid_o,
  output logic [IDX_W-1:0]     rd_idx_o,
  output logic [WORD_W-1:0]    rd_data_o
);
  cam_op_e              op;
  logic [WORD_W-1:0]    word_data [NUM_WORDS];
  logic [NUM_WORDS-1:0] word_valid;
  logic [NUM_WORDS-1:0] hit;
  logic [NUM_WORDS-1:0] match_q;
  logic                 sel_any;
  logic [IDX_W-1:0]     sel_idx;
  logic [NUM_WORDS-1:0] sel_oh;
  logic                 rd_valid_q;
  logic [IDX_W-1:0]     rd_idx_q;
  logic [WORD_W-1:0]    rd_data_q;

  // write > search > read
  always_comb begin
    if (wr_en_i)        op = OP_WRITE;
    else if (srch_en_i) op = OP_SEARCH;
    else if (rd_en_i)   op = OP_READ;
    else                op = OP_IDLE;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    cam_word #(.WORD_W(WORD_W)) u_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (op == OP_WRITE && wr_idx_i == IDX_W'(w)),
      .wdata_i (wr_data_i),
      .arg_i   (arg_i),
      .key_i   (key_i),
      .data_o  (word_data[w]),
      .valid_o (word_valid[w]),
      .hit_o   (hit[w])
    );
  end

  cam_first_sel #(.N(NUM_WORDS)) u_sel (
    .req_i (match_q),
    .any_o (sel_any),
    .idx_o (sel_idx),
    .oh_o  (sel_oh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_idx_q   <= '0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (op)
        OP_WRITE:  match_q <= '0;
        OP_SEARCH: match_q <= hit;
        OP_READ: begin
          if (sel_any) begin
            match_q    <= match_q & ~sel_oh;
            rd_valid_q <= 1'b1;
            rd_idx_q   <= sel_idx;
            rd_data_q  <= word_data[sel_idx];
          end
        end
        default: ;
      endcase
    end
  end

  assign match_o    = match_q;
  assign rd_done_o  = ~|match_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_idx_o   = rd_idx_q;
  assign rd_data_o  = rd_data_q;

  logic [NUM_WORDS-1:0] below_rd;
  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) below_rd[i] = (i < int'(rd_idx_o));
  end

  AST_WR_CLEARS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (match_o == '0 && !rd_valid_o)); // R9
  AST_INVALID_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_en_i && !wr_en_i) |=> ((match_o & ~$past(word_valid)) == '0)); // R5
  AST_READ_DROPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && !srch_en_i && match_o != '0)
      |=> ($countones(match_o) == $countones($past(match_o)) - 1 && rd_valid_o)); // R6
  AST_READ_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (($past(match_o) & below_rd) == '0)); // R6
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && !srch_en_i && match_o == '0) |=> (!rd_valid_o && match_o == '0)); // R7
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_oh)); // R6
endmodule

// File: tb/test_masked_cam.sv
module test_masked_cam;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int WW = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, srch_en = 1'b0, rd_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [WW-1:0] wr_data = '0, arg = '0, key = '0;
  logic [NW-1:0] match;
  logic          done, rd_valid;
  logic [IW-1:0] rd_idx;
  logic [WW-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  logic [WW-1:0] m_mem [NW];
  logic [NW-1:0] m_vld = '0;
  logic [NW-1:0] m_match = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  masked_cam i_masked_cam (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .srch_en_i(srch_en), .arg_i(arg), .key_i(key), .rd_en_i(rd_en),
    .match_o(match), .rd_done_o(done), .rd_valid_o(rd_valid),
    .rd_idx_o(rd_idx), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NW-1:0] model_search(input logic [WW-1:0] a, input logic [WW-1:0] k);
    logic [NW-1:0] r = '0;
    for (int i = 0; i < NW; i++)
      r[i] = m_vld[i] && (((m_mem[i] ^ a) & k) == '0);
    return r;
  endfunction

  function automatic int lowest(input logic [NW-1:0] v);
    for (int i = 0; i < NW; i++) if (v[i]) return i;
    return -1;
  endfunction

  // one operation: drive on a falling edge, check at the next falling edge
  task automatic op(input bit w, input bit s, input bit r, input logic [IW-1:0] idx,
                    input logic [WW-1:0] d, input logic [WW-1:0] a, input logic [WW-1:0] k,
                    input string tag);
    bit exp_rv = 1'b0;
    int lo = -1;
    logic [WW-1:0] exp_d = '0;
    @(negedge clk);
    wr_en = w; srch_en = s; rd_en = r;
    wr_idx = idx; wr_data = d; arg = a; key = k;
    if (w) begin
      m_mem[idx] = d; m_vld[idx] = 1'b1; m_match = '0;
    end else if (s) begin
      m_match = model_search(a, k);
    end else if (r) begin
      lo = lowest(m_match);
      if (lo >= 0) begin
        exp_rv = 1'b1; exp_d = m_mem[lo]; m_match[lo] = 1'b0;
      end
    end
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0; rd_en = 1'b0;
    chk(match == m_match, tag, 32'(match), 32'(m_match));
    chk(done == (m_match == '0), "R8", 32'(done), 32'(m_match == '0));
    chk(rd_valid == exp_rv, w ? "R9" : (r ? (exp_rv ? "R6" : "R7") : tag), 32'(rd_valid), 32'(exp_rv));
    if (exp_rv) begin
      chk(rd_idx == IW'(lo), "R6", 32'(rd_idx), 32'(lo));
      chk(rd_data == exp_d, "R6", 32'(rd_data), 32'(exp_d));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < NW; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(match == '0, "R1", 32'(match), 0);
    chk(done == 1'b1, "R1", 32'(done), 1);
    chk(rd_valid == 1'b0, "R1", 32'(rd_valid), 0);
    rst_n = 1'b1;

    op(0, 1, 0, 0, 0, 8'h00, 8'h00, "R1");          // nothing valid yet
    op(0, 0, 1, 0, 0, 0, 0, "R7");
    op(1, 0, 0, 4'd3, 8'hA5, 0, 0, "R2");
    op(1, 0, 0, 4'd0, 8'hA4, 0, 0, "R2");
    op(1, 0, 0, 4'd15, 8'h35, 0, 0, "R2");
    op(1, 0, 0, 4'd9, 8'h5A, 0, 0, "R2");
    op(0, 1, 0, 0, 0, 8'hA5, 8'hFF, "R2");          // exact hit at 3
    op(0, 1, 0, 0, 0, 8'hA5, 8'h0F, "R3");          // low nibble: 3, 15
    op(0, 1, 0, 0, 0, 8'hFF, 8'h00, "R4");          // every valid word
    op(0, 0, 1, 0, 0, 0, 0, "R6");
    op(0, 0, 1, 0, 0, 0, 0, "R6");
    op(0, 1, 0, 0, 0, 8'h5A, 8'hFF, "R10");         // stale bits dropped
    op(0, 0, 1, 0, 0, 0, 0, "R6");
    op(0, 0, 1, 0, 0, 0, 0, "R7");
    op(0, 1, 0, 0, 0, 8'h00, 8'h00, "R5");
    op(1, 1, 0, 4'd7, 8'h11, 8'h00, 8'h00, "R9");   // write wins over search
    op(0, 1, 0, 0, 0, 8'h00, 8'h00, "R4");
    op(1, 0, 1, 4'd8, 8'h22, 0, 0, "R9");           // write wins over read

    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 9);
      logic [WW-1:0] k = WW'($urandom);
      logic [WW-1:0] a = m_mem[$urandom_range(0, NW - 1)] ^ WW'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) k = '0;
      if ($urandom_range(0, 7) == 0) k = '1;
      if (sel < 3)
        op(1, $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
           IW'($urandom), WW'($urandom), a, k, "R2");
      else if (sel < 5)
        op(0, 1, $urandom_range(0, 1), 0, 0, a, k, "R3");
      else
        op(0, 0, 1, 0, 0, 0, 0, "R6");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule